// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-latency, multi-bank DRAM and walks the device from reset to a usable state. It waits in an idle state with the device held in reset and clock enable low. A start request releases the device reset and raises clock enable. It then keeps the command bus in the inhibit encoding for a stabilization window, given as a cycle count derived from the clock frequency and a wait time in microseconds. After the window it loads the mode register and issues a DLL reset, then polls the DLL ready input until lock is seen or a timeout runs out.

On lock, the block gives the strobe training engine a one-cycle start pulse. It reports done once that engine signals completion. If the timeout expires first, it raises a training error that stays set until reset. The write latency, DLL enable and duty-cycle-correction enable fields of the mode word are captured when the start request is accepted. The burst field always selects eight-word bursts.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst` is high, and in the idle state after it, `dev_rst_n_o`=0, `cke_o`=0, `cmd_o`=3'b111 (inhibit), `addr_o`=0, and `train_start_o`, `done_o`, `err_o` are all 0.
- R2: A `start_i` sampled high in the idle state makes `dev_rst_n_o` and `cke_o` go to 1 in the next cycle, and both stay 1 until `rst`.
- R3: Starting in the cycle after the start request is accepted, `cmd_o` shows only inhibit (3'b111) for exactly WAIT_CYC = CLK_MHZ*WAIT_US cycles.
- R4: The cycle after the stabilization window carries `cmd_o`=3'b000 (mode set), with `addr_o[4:2]` = write latency, `addr_o[5]` = DLL enable, `addr_o[6]` = duty-cycle-correction enable, `addr_o[7]`=0 and all higher bits 0. The field values are the ones present on the inputs in the cycle `start_i` was accepted.
- R5: Every mode-set cycle carries `addr_o[1:0]`=2'b11, which selects a fixed burst of eight words.
- R6: The cycle after the mode load repeats `cmd_o`=3'b000 with the same fields and `addr_o[7]`=1, which resets the DLL.
- R7: Polling starts the cycle after the DLL reset, with `cmd_o`=3'b011 (no-op). A `dll_rdy_i` sampled high in poll cycle k (0 ≤ k < TIMEOUT_CYC) makes `train_start_o` high for exactly the next cycle. `dll_rdy_i` has no effect outside polling.
- R8: If `dll_rdy_i` stays low for TIMEOUT_CYC poll cycles, `err_o` rises in the next cycle and stays high until `rst`, with `cmd_o` at no-op and no training start.
- R9: A `train_done_i` sampled high after the training start pulse sets `done_o` in the next cycle, and `done_o` stays high until `rst`.
- R10: `start_i` is ignored in every state other than idle: it neither changes the sequence timing nor leaves the done or error state.
- R11: `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the power-up sequence (honoured only when idle) |
| wlat_i | input | 3 | Write latency field for the mode word |
| dll_en_i | input | 1 | DLL enable field for the mode word |
| dcc_en_i | input | 1 | Duty-cycle-correction enable field for the mode word |
| dll_rdy_i | input | 1 | DLL lock indication from the device |
| train_done_i | input | 1 | Completion from the strobe training engine |
| dev_rst_n_o | output | 1 | Active-low device reset |
| cke_o | output | 1 | Device clock enable |
| cmd_o | output | 3 | Command code: 111 inhibit, 011 no-op, 000 mode set |
| addr_o | output | ADDR_W | Address bus carrying the mode word |
| train_start_o | output | 1 | One-cycle start pulse to the training engine |
| done_o | output | 1 | Initialization complete |
| err_o | output | 1 | Sticky DLL lock timeout error |

## Verification
A wrong state or a miscounted window shows up directly on `cmd_o`. If the mode set arrives one cycle early or late, the inhibit run on the bus is visibly shorter or longer than WAIT_CYC, and the cycle where the run ends exposes it. A wrong captured configuration shows in the mode word in the first mode-set cycle. An off-by-one in the poll counter shows at the lock edge case, where ready arrives in the last poll cycle, and at the following edge as a wrong `err_o` or `train_start_o`. A stuck or leaking status state appears within one cycle of a stray start request or of reset.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_NOP = 3'b011,
        CMD_INH = 3'b111
    } cmd_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAIT,
        S_MRS,
        S_DLLR,
        S_POLL,
        S_KICK,
        S_TRAIN,
        S_DONE,
        S_ERR
    } seq_state_e;

    typedef struct packed {
        logic       dcc_en;
        logic       dll_en;
        logic [2:0] wlat;
    } mode_cfg_t;

    localparam logic [1:0] BURST_EIGHT = 2'b11;
    localparam int         MR_BITS     = 8;

    // Mode word: [7] DLL reset, [6] DCC, [5] DLL enable, [4:2] WL, [1:0] burst
    function automatic logic [MR_BITS-1:0] mode_word(mode_cfg_t c, logic dll_rst);
        return {dll_rst, c.dcc_en, c.dll_en, c.wlat, BURST_EIGHT};
    endfunction

    function automatic int max_int(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_init_cnt.sv
module dram_init_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         en_i,
    input  logic [W-1:0] lim_i,
    output logic         tc_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  q <= '0;
        else if (en_i)     q <= q + 1'b1;
    end

    assign tc_o = (q == lim_i);

    // R3 / R8: an enabled window never runs past its limit
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        en_i |-> (q <= lim_i));

endmodule

// File: rtl/dram_init_mr.sv
module dram_init_mr
    import dram_init_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  mode_cfg_t          cfg_i,
    input  logic               dll_rst_i,
    input  logic               drive_i,
    output logic [ADDR_W-1:0]  addr_o
);
    logic [MR_BITS-1:0] word;

    assign word = mode_word(cfg_i, dll_rst_i);

    generate
        if (ADDR_W > MR_BITS) begin : g_pad
            assign addr_o = drive_i ? {{(ADDR_W-MR_BITS){1'b0}}, word} : '0;
        end else begin : g_trim
            assign addr_o = drive_i ? word[ADDR_W-1:0] : '0;
        end
    endgenerate

endmodule

// File: rtl/dram_init_fsm.sv
module dram_init_fsm
    import dram_init_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  dll_rdy_i,
    input  logic  train_done_i,
    input  logic  tc_i,
    output logic  cnt_en_o,
    output logic  cnt_clr_o,
    output logic  sel_poll_o,
    output logic  cfg_load_o,
    output logic  mr_drive_o,
    output logic  dll_rst_o,
    output logic  dev_rst_n_o,
    output logic  cke_o,
    output cmd_e  cmd_o,
    output logic  train_start_o,
    output logic  done_o,
    output logic  err_o
);
    seq_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start_i) nxt = S_WAIT;
            S_WAIT:  if (tc_i)    nxt = S_MRS;
            S_MRS:   nxt = S_DLLR;
            S_DLLR:  nxt = S_POLL;
            S_POLL: begin
                if (dll_rdy_i)  nxt = S_KICK;
                else if (tc_i)  nxt = S_ERR;
            end
            S_KICK:  nxt = S_TRAIN;
            S_TRAIN: if (train_done_i) nxt = S_DONE;
            S_DONE:  nxt = S_DONE;
            S_ERR:   nxt = S_ERR;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        cnt_en_o   = (state == S_WAIT) || (state == S_POLL);
        cnt_clr_o  = !cnt_en_o || tc_i;
        sel_poll_o = (state == S_POLL);
        cfg_load_o = (state == S_IDLE) && start_i;
        mr_drive_o = (state == S_MRS) || (state == S_DLLR);
        dll_rst_o  = (state == S_DLLR);
        dev_rst_n_o = (state != S_IDLE);
        cke_o       = (state != S_IDLE);
        train_start_o = (state == S_KICK);
        done_o        = (state == S_DONE);
        err_o         = (state == S_ERR);
        case (state)
            S_IDLE, S_WAIT: cmd_o = CMD_INH;
            S_MRS, S_DLLR:  cmd_o = CMD_MRS;
            default:        cmd_o = CMD_NOP;
        endcase
    end

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
        cke_o |=> cke_o);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> (err_o && !train_start_o));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

    assert_kick_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        train_start_o |=> !train_start_o);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
    import dram_init_pkg::*;
#(
    parameter int CLK_MHZ     = 200,
    parameter int WAIT_US     = 200,
    parameter int TIMEOUT_CYC = 1024,
    parameter int ADDR_W      = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [2:0]        wlat_i,
    input  logic              dll_en_i,
    input  logic              dcc_en_i,
    input  logic              dll_rdy_i,
    input  logic              train_done_i,
    output logic              dev_rst_n_o,
    output logic              cke_o,
    output logic [2:0]        cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              train_start_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int MAX_CYC  = max_int(WAIT_CYC, TIMEOUT_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] POLL_LIM = CNT_W'(TIMEOUT_CYC - 1);

    logic      cnt_en, cnt_clr, sel_poll, tc;
    logic      cfg_load, mr_drive, dll_rst;
    cmd_e      cmd;
    mode_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)           cfg_q <= '0;
        else if (cfg_load) cfg_q <= '{dcc_en: dcc_en_i, dll_en: dll_en_i, wlat: wlat_i};
    end

    dram_init_cnt #(.W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst   (rst),
        .clr_i (cnt_clr),
        .en_i  (cnt_en),
        .lim_i (sel_poll ? POLL_LIM : WAIT_LIM),
        .tc_o  (tc)
    );

    dram_init_fsm fsm_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .dll_rdy_i     (dll_rdy_i),
        .train_done_i  (train_done_i),
        .tc_i          (tc),
        .cnt_en_o      (cnt_en),
        .cnt_clr_o     (cnt_clr),
        .sel_poll_o    (sel_poll),
        .cfg_load_o    (cfg_load),
        .mr_drive_o    (mr_drive),
        .dll_rst_o     (dll_rst),
        .dev_rst_n_o   (dev_rst_n_o),
        .cke_o         (cke_o),
        .cmd_o         (cmd),
        .train_start_o (train_start_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    dram_init_mr #(.ADDR_W(ADDR_W)) mr_i (
        .cfg_i     (cfg_q),
        .dll_rst_i (dll_rst),
        .drive_i   (mr_drive),
        .addr_o    (addr_o)
    );

    assign cmd_o = cmd;

    // Checker: cycles elapsed since clock enable went active (saturating)
    logic [CNT_W-1:0] chk_since;
    always_ff @(posedge clk) begin
        if (rst)                                        chk_since <= '0;
        else if (cke_o && chk_since != CNT_W'(WAIT_CYC)) chk_since <= chk_since + 1'b1;
    end

    assert_inhibit_window_R3: assert property (@(posedge clk) disable iff (rst)
        (cke_o && chk_since < CNT_W'(WAIT_CYC)) |-> (cmd_o == 3'b111));

    assert_mrs_after_window_R4: assert property (@(posedge clk) disable iff (rst)
        (cke_o && chk_since == CNT_W'(WAIT_CYC) && $past(cmd_o) == 3'b111)
            |-> (cmd_o == 3'b000 && !addr_o[7]));

    assert_dll_reset_follows_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'b000 && !addr_o[7]) |=>
            (cmd_o == 3'b000 && addr_o[7] && addr_o[6:0] == $past(addr_o[6:0])));

    assert_burst_eight_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 3'b000) |-> (addr_o[1:0] == 2'b11));

    assert_idle_quiet_R1: assert property (@(posedge clk)
        rst |=> (!cke_o && !dev_rst_n_o && cmd_o == 3'b111 && addr_o == '0));

endmodule

// File: tb/dram_init_seq_tb.sv
`timescale 1ns/1ps
module dram_init_seq_tb_top;

    localparam int CLK_MHZ  = 10;
    localparam int WAIT_US  = 2;
    localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
    localparam int TMO      = 12;
    localparam int AW       = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [2:0]    wlat_i = '0;
    logic          dll_en_i = 1'b0;
    logic          dcc_en_i = 1'b0;
    logic          dll_rdy_i = 1'b0;
    logic          train_done_i = 1'b0;
    logic          dev_rst_n_o, cke_o, train_start_o, done_o, err_o;
    logic [2:0]    cmd_o;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dram_init_seq #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .TIMEOUT_CYC(TMO), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .wlat_i(wlat_i), .dll_en_i(dll_en_i),
        .dcc_en_i(dcc_en_i), .dll_rdy_i(dll_rdy_i), .train_done_i(train_done_i),
        .dev_rst_n_o(dev_rst_n_o), .cke_o(cke_o), .cmd_o(cmd_o), .addr_o(addr_o),
        .train_start_o(train_start_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_word(input int wl, input bit dll, input bit dcc, input bit dr);
        return (int'(dr) << 7) | (int'(dcc) << 6) | (int'(dll) << 5) | ((wl & 7) << 2) | 3;
    endfunction

    task automatic do_reset();
        rst = 1'b1; start_i = 1'b0; dll_rdy_i = 1'b0; train_done_i = 1'b0;
        step(); step();
        chk(!cke_o && !dev_rst_n_o && cmd_o == 3'b111 && addr_o == '0 && !done_o && !err_o && !train_start_o,
            "R1 in reset", {cke_o, dev_rst_n_o, cmd_o}, 3'b111);
        rst = 1'b0;
        step();
        chk(!cke_o && !dev_rst_n_o && cmd_o == 3'b111 && !done_o && !err_o,
            "R1 idle after reset", {cke_o, dev_rst_n_o, cmd_o}, 3'b111);
    endtask

    // lock_at >= TMO means the DLL never reports lock
    task automatic run_seq(input int wl, input bit dll, input bit dcc, input int lock_at,
                           input int train_lat, input bit stray);
        int ew;
        do_reset();
        wlat_i = 3'(wl); dll_en_i = dll; dcc_en_i = dcc;
        dll_rdy_i = (lock_at == 0);
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        wlat_i = ~3'(wl); dll_en_i = ~dll; dcc_en_i = ~dcc;
        chk(cke_o && dev_rst_n_o, "R2 cke and reset release", {cke_o, dev_rst_n_o}, 2'b11);
        for (int i = 0; i < WAIT_CYC; i++) begin
            chk(cmd_o == 3'b111 && cke_o, "R3 inhibit during wait", cmd_o, 3'b111);
            start_i = stray ? 1'($urandom % 2) : 1'b0;
            step();
        end
        start_i = 1'b0;
        ew = exp_word(wl, dll, dcc, 1'b0);
        chk(cmd_o == 3'b000, "R4 mode set command", cmd_o, 0);
        chk(int'(addr_o) == ew, "R4 mode word fields", int'(addr_o), ew);
        chk(addr_o[1:0] == 2'b11, "R5 burst eight", addr_o[1:0], 3);
        step();
        ew = exp_word(wl, dll, dcc, 1'b1);
        chk(cmd_o == 3'b000 && int'(addr_o) == ew, "R6 DLL reset word", int'(addr_o), ew);
        step();
        for (int p = 0; p < TMO; p++) begin
            dll_rdy_i = (p >= lock_at);
            chk(cmd_o == 3'b011 && !train_start_o && !err_o, "R7 polling no-op", cmd_o, 3);
            start_i = stray ? 1'($urandom % 2) : 1'b0;
            step();
            if (dll_rdy_i) break;
        end
        start_i = 1'b0;
        if (lock_at < TMO) begin
            dll_rdy_i = 1'b0;
            chk(train_start_o && !err_o, "R7 training start pulse", train_start_o, 1);
            step();
            chk(!train_start_o, "R7 pulse is one cycle", train_start_o, 0);
            for (int t = 0; t < train_lat; t++) begin
                chk(!done_o, "R9 done waits for training", done_o, 0);
                step();
            end
            train_done_i = 1'b1;
            step();
            train_done_i = 1'b0;
            chk(done_o && !err_o, "R9 done after training", {done_o, err_o}, 2'b10);
            start_i = 1'b1; dll_rdy_i = 1'b1;
            step(); step();
            start_i = 1'b0; dll_rdy_i = 1'b0;
            chk(done_o && cke_o && cmd_o == 3'b011 && !train_start_o, "R10 start ignored when done",
                {done_o, cke_o, cmd_o}, 5'b11011);
            chk(!(done_o && err_o), "R11 exclusive status", {done_o, err_o}, 2'b10);
        end else begin
            chk(err_o && !done_o && !train_start_o, "R8 timeout error", {err_o, done_o}, 2'b10);
            dll_rdy_i = 1'b1; start_i = 1'b1; train_done_i = 1'b1;
            step(); step(); step();
            dll_rdy_i = 1'b0; start_i = 1'b0; train_done_i = 1'b0;
            chk(err_o && cmd_o == 3'b011 && !train_start_o, "R8 error sticky", {err_o, cmd_o}, 4'b1011);
            chk(!done_o && cke_o, "R10 R11 start ignored in error", {done_o, cke_o}, 2'b01);
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4242));
        // directed corners
        run_seq(5, 1'b1, 1'b0, 0, 0, 1'b0);        // lock at first poll cycle
        run_seq(2, 1'b0, 1'b1, TMO - 1, 3, 1'b1);  // lock in last poll cycle
        run_seq(7, 1'b1, 1'b1, TMO, 0, 1'b1);      // exact timeout
        // reset mid-sequence returns to idle
        do_reset();
        start_i = 1'b1; step(); start_i = 1'b0; step();
        rst = 1'b1; step(); rst = 1'b0; step();
        chk(!cke_o && cmd_o == 3'b111 && !done_o && !err_o, "R1 reset aborts sequence", cke_o, 0);
        // random runs
        for (int n = 0; n < 14; n++) begin
            run_seq(int'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2),
                    int'($urandom % (TMO + 3)), int'($urandom % 5), 1'($urandom % 2));
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule